// File: doc/BRIEF.md
# Segmented Physical Address Generator

This block turns a 16-bit segment base and a 16-bit offset into a 20-bit physical address. It holds four segment base registers: code, data, stack and extra. The physical address is the selected base shifted left by four bit positions plus the offset. Any carry past the top address bit is discarded, so the reachable space is 1 MB and addresses wrap inside it.

For each access the block picks a segment from the kind of access and the base register that produced the offset. Instruction fetches always use the code segment. The destination of a string operation always uses the extra segment. Ordinary data accesses use the stack segment when the base register is the stack pointer or the frame pointer, and the data segment otherwise. An ordinary data access can also name a segment directly through an override input.

The offset arrives already computed. The block returns the physical address and the code of the segment it used, both combinationally in the same cycle.

Top module: `seg_addr_gen`

## Requirements
- R1: `phys_addr_o` equals (selected base × 16 + `offset_i`) modulo 2^20, so its low four bits always equal the offset's low four bits. For example, a code base of 010Ah with offset F950h gives 109F0h.
- R2: A sum that carries past bit 19 wraps. A base of FFFFh with offset 0010h gives 00000h, and with offset 000Fh it gives FFFFFh.
- R3: Access type 0 (instruction fetch) selects the code segment, with segment code 1. It ignores both the base code and the override.
- R4: Access type 1 or 3 (data) with no override and base code 4 (stack pointer) or 5 (frame pointer) selects the stack segment, with segment code 2.
- R5: Access type 1 or 3 with no override and base code 0–3 (the four general registers) or 6–7 (source and destination index) selects the data segment, with segment code 3.
- R6: Access type 2 (string destination) selects the extra segment, with segment code 0. It ignores both the base code and the override.
- R7: For access type 1 or 3, when `ovr_en_i` is 1, the segment named by `ovr_seg_i` is used in place of the default. The segment codes are extra 0, code 1, stack 2 and data 3.
- R8: A write through `seg_we_i`/`seg_wsel_i`/`seg_wdata_i` (with `seg_wsel_i` taking the segment codes above) is captured at the rising clock edge. The address in the same cycle still uses the old value, and later cycles use the new one.
- R9: While `rst_ni` is low, all four segment registers are cleared to zero, so after reset the physical address equals the offset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| access_i | input | 2 | Access kind: 0 fetch, 1 data, 2 string destination, 3 data |
| base_i | input | 3 | Base register code: 0–3 general, 4 stack pointer, 5 frame pointer, 6 source index, 7 destination index |
| ovr_en_i | input | 1 | Segment override enable for data accesses |
| ovr_seg_i | input | 2 | Segment code used when the override is enabled |
| offset_i | input | 16 | Precomputed offset |
| seg_we_i | input | 1 | Segment register write enable |
| seg_wsel_i | input | 2 | Segment code of the register written |
| seg_wdata_i | input | 16 | New segment base value |
| phys_addr_o | output | 20 | Physical address |
| seg_sel_o | output | 2 | Code of the segment used |

## Verification
The four bases are loaded with distinct values, so the upper address digit alone identifies which segment took part. Each access kind is then driven with every class of base register, with the override both on and off. Fetches and string destinations carrying an override show that the override is ignored on those paths. Data accesses through the stack pointer or frame pointer with an override show that the override beats the stack default. A base of FFFFh with small offsets separates a wrapping adder from one that keeps the carry. A write paired with a read of the same segment, sampled before and after the edge, pins down when a new base takes effect.

// File: rtl/seg_addr_pkg.sv
package seg_addr_pkg;
  localparam int NUM_SEG = 4;

  typedef enum logic [1:0] {
    SEG_ES = 2'd0,
    SEG_CS = 2'd1,
    SEG_SS = 2'd2,
    SEG_DS = 2'd3
  } seg_id_e;

  typedef enum logic [1:0] {
    ACC_FETCH    = 2'd0,
    ACC_DATA     = 2'd1,
    ACC_STR_DST  = 2'd2,
    ACC_DATA_ALT = 2'd3
  } acc_e;

  typedef enum logic [2:0] {
    BR_G0 = 3'd0,
    BR_G1 = 3'd1,
    BR_G2 = 3'd2,
    BR_G3 = 3'd3,
    BR_SP = 3'd4,
    BR_FP = 3'd5,
    BR_SRC = 3'd6,
    BR_DST = 3'd7
  } base_e;
endpackage

// File: rtl/seg_regs.sv
module seg_regs
  import seg_addr_pkg::*;
#(
  parameter int SEG_W = 16,
  parameter int N_SEG = NUM_SEG,
  localparam int IDX_W = $clog2(N_SEG)
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        we_i,
  input  logic [IDX_W-1:0]            wsel_i,
  input  logic [SEG_W-1:0]            wdata_i,
  output logic [N_SEG-1:0][SEG_W-1:0] seg_q_o
);
  for (genvar g = 0; g < N_SEG; g++) begin : g_seg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                              seg_q_o[g] <= '0;
      else if (we_i && wsel_i == IDX_W'(g))     seg_q_o[g] <= wdata_i;
    end
  end
endmodule

// File: rtl/seg_select.sv
module seg_select
  import seg_addr_pkg::*;
(
  input  logic [1:0] access_i,
  input  logic [2:0] base_i,
  input  logic       ovr_en_i,
  input  logic [1:0] ovr_seg_i,
  output logic [1:0] sel_o
);
  acc_e  acc;
  base_e base;
  seg_id_e sel;

  assign acc  = acc_e'(access_i);
  assign base = base_e'(base_i);

  always_comb begin
    unique case (acc)
      ACC_FETCH:   sel = SEG_CS;
      ACC_STR_DST: sel = SEG_ES;  // fixed, never overridden
      default: begin
        if (ovr_en_i)                             sel = seg_id_e'(ovr_seg_i);
        else if (base == BR_SP || base == BR_FP)  sel = SEG_SS;
        else                                      sel = SEG_DS;
      end
    endcase
  end

  assign sel_o = sel;
endmodule

// File: rtl/seg_addr_sum.sv
module seg_addr_sum #(
  parameter int SEG_W = 16,
  parameter int OFF_W = 16,
  parameter int SHIFT = 4,
  localparam int ADDR_W = SEG_W + SHIFT
) (
  input  logic [SEG_W-1:0]  seg_i,
  input  logic [OFF_W-1:0]  off_i,
  output logic [ADDR_W-1:0] addr_o
);
  logic [ADDR_W-1:0] seg_ext;
  logic [ADDR_W-1:0] off_ext;

  assign seg_ext = {seg_i, {SHIFT{1'b0}}};
  assign off_ext = ADDR_W'(off_i);
  // carry beyond the top bit is dropped: wraps inside the space
  assign addr_o  = seg_ext + off_ext;
endmodule

// File: rtl/seg_addr_gen.sv
module seg_addr_gen
  import seg_addr_pkg::*;
#(
  parameter int SEG_W = 16,
  parameter int OFF_W = 16,
  parameter int SHIFT = 4,
  localparam int ADDR_W = SEG_W + SHIFT
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [1:0]        access_i,
  input  logic [2:0]        base_i,
  input  logic              ovr_en_i,
  input  logic [1:0]        ovr_seg_i,
  input  logic [OFF_W-1:0]  offset_i,
  input  logic              seg_we_i,
  input  logic [1:0]        seg_wsel_i,
  input  logic [SEG_W-1:0]  seg_wdata_i,
  output logic [ADDR_W-1:0] phys_addr_o,
  output logic [1:0]        seg_sel_o
);
  logic [NUM_SEG-1:0][SEG_W-1:0] seg_q;
  logic [1:0]                    sel;

  seg_regs #(.SEG_W(SEG_W), .N_SEG(NUM_SEG)) u_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (seg_we_i),
    .wsel_i  (seg_wsel_i),
    .wdata_i (seg_wdata_i),
    .seg_q_o (seg_q)
  );

  seg_select u_sel (
    .access_i  (access_i),
    .base_i    (base_i),
    .ovr_en_i  (ovr_en_i),
    .ovr_seg_i (ovr_seg_i),
    .sel_o     (sel)
  );

  seg_addr_sum #(.SEG_W(SEG_W), .OFF_W(OFF_W), .SHIFT(SHIFT)) u_sum (
    .seg_i  (seg_q[sel]),
    .off_i  (offset_i),
    .addr_o (phys_addr_o)
  );

  assign seg_sel_o = sel;
endmodule

// File: rtl/seg_addr_gen_chk.sv
module seg_addr_gen_chk #(
  parameter int OFF_W  = 16,
  parameter int ADDR_W = 20
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [1:0]        access_i,
  input logic [2:0]        base_i,
  input logic              ovr_en_i,
  input logic [1:0]        ovr_seg_i,
  input logic [OFF_W-1:0]  offset_i,
  input logic              seg_we_i,
  input logic [ADDR_W-1:0] phys_addr_o,
  input logic [1:0]        seg_sel_o
);
  AST_LOW_NIBBLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    phys_addr_o[3:0] == offset_i[3:0]); // R1

  AST_FETCH_CODE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    access_i == 2'd0 |-> seg_sel_o == 2'd1); // R3

  AST_STACK_DEFAULT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (access_i[0] && !ovr_en_i && (base_i == 3'd4 || base_i == 3'd5)) |-> seg_sel_o == 2'd2); // R4

  AST_DATA_DEFAULT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (access_i[0] && !ovr_en_i && base_i != 3'd4 && base_i != 3'd5) |-> seg_sel_o == 2'd3); // R5

  AST_STRDST_EXTRA: assert property (@(posedge clk_i) disable iff (!rst_ni)
    access_i == 2'd2 |-> seg_sel_o == 2'd0); // R6

  AST_OVR_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (access_i[0] && ovr_en_i) |-> seg_sel_o == ovr_seg_i); // R7

  AST_NO_WRITE_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!seg_we_i ##1 ($stable(access_i) && $stable(base_i) && $stable(ovr_en_i)
                    && $stable(ovr_seg_i) && $stable(offset_i)))
    |-> $stable(phys_addr_o)); // R8
endmodule

bind seg_addr_gen seg_addr_gen_chk #(.OFF_W(OFF_W), .ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/seg_addr_gen_test.sv
module seg_addr_gen_test;
  localparam int CLK_P = 10;

  typedef struct packed {
    logic [1:0]  acc;
    logic [2:0]  base;
    logic        oen;
    logic [1:0]  oseg;
    logic [15:0] off;
    logic [19:0] exp_addr;
    logic [1:0]  exp_sel;
  } vec_t;

  // bases: CS=010A DS=2000 SS=3000 ES=4000
  localparam vec_t VEC [12] = '{
    '{2'd0, 3'd0, 1'b0, 2'd0, 16'hF950, 20'h109F0, 2'd1}, // R1 R3
    '{2'd0, 3'd4, 1'b1, 2'd3, 16'h0010, 20'h010B0, 2'd1}, // R3 override ignored
    '{2'd1, 3'd4, 1'b0, 2'd0, 16'h0100, 20'h30100, 2'd2}, // R4
    '{2'd1, 3'd5, 1'b0, 2'd0, 16'h1234, 20'h31234, 2'd2}, // R4
    '{2'd1, 3'd0, 1'b0, 2'd0, 16'h0005, 20'h20005, 2'd3}, // R5
    '{2'd1, 3'd6, 1'b0, 2'd0, 16'hFFFF, 20'h2FFFF, 2'd3}, // R5
    '{2'd1, 3'd7, 1'b0, 2'd0, 16'h0000, 20'h20000, 2'd3}, // R5
    '{2'd2, 3'd6, 1'b1, 2'd1, 16'h0002, 20'h40002, 2'd0}, // R6
    '{2'd1, 3'd3, 1'b1, 2'd0, 16'h0003, 20'h40003, 2'd0}, // R7
    '{2'd1, 3'd5, 1'b1, 2'd3, 16'h0004, 20'h20004, 2'd3}, // R7 beats stack
    '{2'd3, 3'd1, 1'b0, 2'd0, 16'h0007, 20'h20007, 2'd3}, // R5 type 3
    '{2'd3, 3'd2, 1'b1, 2'd1, 16'h0001, 20'h010A1, 2'd1}  // R7 type 3
  };

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [1:0]  access_i = '0;
  logic [2:0]  base_i = '0;
  logic        ovr_en_i = 1'b0;
  logic [1:0]  ovr_seg_i = '0;
  logic [15:0] offset_i = '0;
  logic        seg_we_i = 1'b0;
  logic [1:0]  seg_wsel_i = '0;
  logic [15:0] seg_wdata_i = '0;
  logic [19:0] phys_addr_o;
  logic [1:0]  seg_sel_o;

  int checks = 0;
  int failures = 0;

  always #(CLK_P/2) clk_i = ~clk_i;

  seg_addr_gen uut (.*);

  task automatic chk(input string tag, input logic [19:0] act, input logic [19:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%05h expected=%05h", tag, act, exp);
    end
  endtask

  task automatic wr_seg(input logic [1:0] s, input logic [15:0] v);
    @(negedge clk_i);
    seg_we_i = 1'b1; seg_wsel_i = s; seg_wdata_i = v;
    @(negedge clk_i);
    seg_we_i = 1'b0;
  endtask

  task automatic drive(input logic [1:0] a, input logic [2:0] b, input logic oe,
                       input logic [1:0] os, input logic [15:0] o);
    access_i = a; base_i = b; ovr_en_i = oe; ovr_seg_i = os; offset_i = o;
    #1;
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    // R9: all bases zero in reset and right after it
    drive(2'd1, 3'd0, 1'b0, 2'd0, 16'h1234);
    chk("R9 during reset", phys_addr_o, 20'h01234);
    rst_ni = 1'b1;
    @(negedge clk_i);
    drive(2'd0, 3'd0, 1'b0, 2'd0, 16'hABCD);
    chk("R9 code base zero", phys_addr_o, 20'h0ABCD);
    drive(2'd2, 3'd0, 1'b0, 2'd0, 16'h0042);
    chk("R9 extra base zero", phys_addr_o, 20'h00042);
    drive(2'd1, 3'd4, 1'b0, 2'd0, 16'h0099);
    chk("R9 stack base zero", phys_addr_o, 20'h00099);

    wr_seg(2'd1, 16'h010A);
    wr_seg(2'd3, 16'h2000);
    wr_seg(2'd2, 16'h3000);
    wr_seg(2'd0, 16'h4000);

    for (int i = 0; i < 12; i++) begin
      drive(VEC[i].acc, VEC[i].base, VEC[i].oen, VEC[i].oseg, VEC[i].off);
      chk($sformatf("R1 vec%0d addr", i), phys_addr_o, VEC[i].exp_addr);
      chk($sformatf("R3-7 vec%0d sel", i), 20'(seg_sel_o), 20'(VEC[i].exp_sel));
    end

    // R8: write visible only after the edge
    @(negedge clk_i);
    seg_we_i = 1'b1; seg_wsel_i = 2'd3; seg_wdata_i = 16'h5555;
    drive(2'd1, 3'd0, 1'b0, 2'd0, 16'h0001);
    chk("R8 old value same cycle", phys_addr_o, 20'h20001);
    @(posedge clk_i);
    #1;
    seg_we_i = 1'b0;
    chk("R8 new value next cycle", phys_addr_o, 20'h55551);
    drive(2'd1, 3'd4, 1'b0, 2'd0, 16'h0001);
    chk("R8 other base untouched", phys_addr_o, 20'h30001);

    // R2: wrap at the top of the space
    wr_seg(2'd3, 16'hFFFF);
    drive(2'd1, 3'd7, 1'b0, 2'd0, 16'h0010);
    chk("R2 wrap to zero", phys_addr_o, 20'h00000);
    drive(2'd1, 3'd7, 1'b0, 2'd0, 16'h000F);
    chk("R2 top address", phys_addr_o, 20'hFFFFF);
    drive(2'd1, 3'd0, 1'b0, 2'd0, 16'hFFFF);
    chk("R2 wrap large offset", phys_addr_o, 20'h0FFEF);

    // R9: reset clears written bases again
    @(negedge clk_i);
    rst_ni = 1'b0;
    #1;
    drive(2'd1, 3'd0, 1'b0, 2'd0, 16'h0020);
    chk("R9 reset clears", phys_addr_o, 20'h00020);
    rst_ni = 1'b1;

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(CLK_P * 100000);
    failures++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule